// File: doc/BRIEF.md
# Ones'-Complement Accumulator Adder

This block is the add path of a 12-bit accumulator machine. Each operation takes the current accumulator word, an operand already fetched from memory, and the current Link bit. It then registers a new accumulator, Link and overflow flag. Two of the three operations also present the result on a write-back port with a one-cycle write strobe. Bit 0 is the most significant bit and the sign (0 positive, 1 negative). In this RTL the sign is `W-1` of each vector.

Two of the operations are ones'-complement additions with end-around carry. One leaves its result in the accumulator only. The other also writes the result back to memory. The third is a chained two's-complement addition. It first adds the Link into the accumulator, then adds the operand to that partial sum. The two carries act on the Link in different ways. Status outputs give the sign, a zero test that accepts both representations of zero, the Link state and the overflow flag, all taken from the registered state.

A caller pulses `start` for one cycle with the operand word, accumulator, Link and operation select. The results appear after the next rising clock edge, together with a one-cycle `done`.

Top module: `ones_acc_adder`

## Requirements
- R1: Operation codes 0 (add) and 1 (add to memory) form the ones'-complement sum: any carry out of the sign bit is added back into the least significant bit (octal 2435+1704 gives 4341, 2435+5704 gives 0342, 4000+4000 gives 0001).
- R2: Operation code 0 writes the sum to `ac_q` only; `wb_we` stays low.
- R3: Operation codes 0 and 1 leave the Link unchanged: `link_q` takes the value of `link_in`.
- R4: Operation code 1 puts the same sum in `ac_q` and `wb_data` and raises `wb_we` for the single cycle in which `done` is high.
- R5: `ovf_q` is set when the two addends have equal sign bits and the result's sign bit differs from them. It is cleared after any add without overflow, and is never set when the addends' signs differ.
- R6: Operation code 2 first forms `ac_in + link_in` in two's complement, with the Link set by a carry out of that step and cleared otherwise. It then adds the operand in two's complement; a carry out of this step sets the Link, and no carry leaves the Link at its step-one value.
- R7: Operation code 2 writes its final sum to `ac_q` and `wb_data` with `wb_we`. Overflow is judged on the second addition only (octal 3743+6517 with Link 1 gives 2463, Link 1).
- R8: `st_zero` is high when `ac_q` is 0000 or 7777 octal. `st_pos` is high when the sign bit of `ac_q` is 0. `st_lnz` is high when `link_q` is 0. `st_ovf` follows `ovf_q`.
- R9: `done` is high for exactly the one cycle after a cycle with `start` high. Operation code 3 is ignored: `ac_q`, `link_q` and `ovf_q` keep their values and `wb_we` stays low.
- R10: A synchronous `rst` clears `ac_q`, `link_q`, `ovf_q`, `done` and `wb_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle launch of an operation |
| op | input | 2 | 0 add, 1 add to memory, 2 link add, 3 ignored |
| ac_in | input | W | Current accumulator word |
| opnd | input | W | Memory operand |
| link_in | input | 1 | Current Link bit |
| ac_q | output | W | Registered new accumulator |
| link_q | output | 1 | Registered new Link |
| ovf_q | output | 1 | Registered overflow flag |
| wb_data | output | W | Write-back word for memory |
| wb_we | output | 1 | Write-back strobe, one cycle |
| done | output | 1 | Result-valid pulse |
| st_pos | output | 1 | Accumulator sign bit is 0 |
| st_zero | output | 1 | Accumulator is +0 or -0 |
| st_lnz | output | 1 | Link is 0 |
| st_ovf | output | 1 | Overflow flag state |

## Verification
The ones'-complement adds are driven with pairs that do and do not carry out of the sign bit. These separate a plain adder from one with end-around carry, and the pair 4000+4000 shows that the wrap can change the sign. Overflow is tried with two positive addends, two negative addends and mixed signs, so a flag driven by carry alone would be caught. The link add is run with carry only in the first step, carry only in the second step, and no carry at all, which separates the set-and-clear rule of step one from the set-only rule of step two. Results of 7777 and 0000 exercise both forms of zero, and operation code 3 checks that the registered state holds.

// File: rtl/ones_acc_adder.sv
module ones_acc_adder #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [1:0]   op,
  input  logic [W-1:0] ac_in,
  input  logic [W-1:0] opnd,
  input  logic         link_in,
  output logic [W-1:0] ac_q,
  output logic         link_q,
  output logic         ovf_q,
  output logic [W-1:0] wb_data,
  output logic         wb_we,
  output logic         done,
  output logic         st_pos,
  output logic         st_zero,
  output logic         st_lnz,
  output logic         st_ovf
);

  localparam logic [1:0] OP_ADD = 2'd0;
  localparam logic [1:0] OP_ADM = 2'd1;
  localparam logic [1:0] OP_LAM = 2'd2;
  localparam int         S      = W - 1;

  // ones'-complement path: end-around carry
  logic [W:0]   raw;
  logic [W-1:0] oc_sum;
  assign raw    = {1'b0, ac_in} + {1'b0, opnd};
  assign oc_sum = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};

  // chained two's-complement link add
  logic [W:0] step1, step2;
  assign step1 = {1'b0, ac_in} + {{W{1'b0}}, link_in};
  assign step2 = {1'b0, step1[W-1:0]} + {1'b0, opnd};

  logic         is_lam;
  logic [W-1:0] addend_a, sum_sel;
  logic         ovf_nxt, link_lam;
  assign is_lam   = (op == OP_LAM);
  assign addend_a = is_lam ? step1[W-1:0] : ac_in;
  assign sum_sel  = is_lam ? step2[W-1:0] : oc_sum;
  assign ovf_nxt  = (addend_a[S] == opnd[S]) && (sum_sel[S] != addend_a[S]);
  assign link_lam = step1[W] | step2[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ac_q    <= '0;
      link_q  <= 1'b0;
      ovf_q   <= 1'b0;
      wb_data <= '0;
      wb_we   <= 1'b0;
      done    <= 1'b0;
    end else begin
      done  <= start;
      wb_we <= start && (op == OP_ADM || op == OP_LAM);
      if (start) begin
        case (op)
          OP_ADD: begin
            ac_q   <= oc_sum;
            link_q <= link_in;
            ovf_q  <= ovf_nxt;
          end
          OP_ADM: begin
            ac_q    <= oc_sum;
            wb_data <= oc_sum;
            link_q  <= link_in;
            ovf_q   <= ovf_nxt;
          end
          OP_LAM: begin
            ac_q    <= sum_sel;
            wb_data <= sum_sel;
            link_q  <= link_lam;
            ovf_q   <= ovf_nxt;
          end
          default: ;
        endcase
      end
    end
  end

  assign st_pos  = ~ac_q[S];
  assign st_zero = (ac_q == '0) || (ac_q == '1);
  assign st_lnz  = ~link_q;
  assign st_ovf  = ovf_q;

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (ac_q == '0 && !link_q && !ovf_q && !done && !wb_we));

  assert_link_kept_R3: assert property (@(posedge clk) disable iff (rst)
    start && (op == OP_ADD || op == OP_ADM) |=> link_q == $past(link_in));

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
    start && (op == OP_ADD || op == OP_ADM) && (ac_in[S] != opnd[S]) |=> !ovf_q);

  assert_wb_matches_acc_R4: assert property (@(posedge clk) disable iff (rst)
    wb_we |-> (done && wb_data == ac_q));

  assert_no_wb_plain_add_R2: assert property (@(posedge clk) disable iff (rst)
    start && op == OP_ADD |=> !wb_we);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  assert_ignored_op_R9: assert property (@(posedge clk) disable iff (rst)
    start && op == 2'd3 |=> ($stable(ac_q) && $stable(link_q) && $stable(ovf_q) && !wb_we));

  assert_lam_first_carry_R6: assert property (@(posedge clk) disable iff (rst)
    start && op == OP_LAM && link_in && (ac_in == '1) |=> link_q);

endmodule

// File: tb/test_ones_acc_adder.sv
module test_ones_acc_adder;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [1:0]   op = 2'd0;
  logic [W-1:0] ac_in = '0, opnd = '0;
  logic         link_in = 1'b0;
  logic [W-1:0] ac_q, wb_data;
  logic         link_q, ovf_q, wb_we, done, st_pos, st_zero, st_lnz, st_ovf;

  ones_acc_adder #(.W(W)) i_ones_acc_adder (
    .clk(clk), .rst(rst), .start(start), .op(op), .ac_in(ac_in), .opnd(opnd),
    .link_in(link_in), .ac_q(ac_q), .link_q(link_q), .ovf_q(ovf_q),
    .wb_data(wb_data), .wb_we(wb_we), .done(done), .st_pos(st_pos),
    .st_zero(st_zero), .st_lnz(st_lnz), .st_ovf(st_ovf));

  always #10 clk = ~clk;

  typedef struct {
    logic [W-1:0] ac;
    logic         lnk;
    logic         ovf;
    logic         we;
    logic [W-1:0] wd;
    string        tag;
  } exp_t;

  exp_t q[$];
  int total = 0, bad = 0;
  bit finished = 0;
  logic [W-1:0] m_ac = '0;
  logic         m_lnk = 1'b0, m_ovf = 1'b0;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0o expected=%0o", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] o, input logic [W-1:0] a, input logic [W-1:0] b,
                     input logic l, input string tag);
    exp_t e;
    int s, t, u;
    bit c1, c2;
    e.tag = tag; e.we = 0; e.wd = 0;
    if (o == 2'd3) begin
      e.ac = m_ac; e.lnk = m_lnk; e.ovf = m_ovf;
    end else if (o == 2'd2) begin
      t = int'(a) + int'(l); c1 = t > 4095; t = t & 4095;
      u = t + int'(b); c2 = u > 4095; u = u & 4095;
      e.ac = W'(u); e.lnk = c1 | c2;
      e.ovf = (t[11] == b[11]) && (u[11] != t[11]);
      e.we = 1; e.wd = W'(u);
    end else begin
      s = int'(a) + int'(b);
      if (s > 4095) s = s - 4095;
      e.ac = W'(s); e.lnk = l;
      e.ovf = (a[11] == b[11]) && (s[11] != a[11]);
      if (o == 2'd1) begin e.we = 1; e.wd = W'(s); end
    end
    m_ac = e.ac; m_lnk = e.lnk; m_ovf = e.ovf;
    q.push_back(e);
    @(negedge clk);
    start = 1; op = o; ac_in = a; opnd = b; link_in = l;
    @(negedge clk);
    start = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    exp_t e;
    if (!rst && !finished) begin
      if (done) begin
        if (q.size() == 0) chk("R9", "unexpected done", 1, 0);
        else begin
          e = q.pop_front();
          chk(e.tag, "ac", ac_q, e.ac);
          chk(e.tag, "link", link_q, e.lnk);
          chk(e.tag, "ovf", ovf_q, e.ovf);
          chk(e.tag, "wb_we", wb_we, e.we);
          if (e.we) chk(e.tag, "wb_data", wb_data, e.wd);
          chk("R8", "st_zero", st_zero, (e.ac == 12'o0000 || e.ac == 12'o7777));
          chk("R8", "st_pos", st_pos, !e.ac[11]);
          chk("R8", "st_lnz", st_lnz, !e.lnk);
          chk("R8", "st_ovf", st_ovf, e.ovf);
        end
      end else if (wb_we) chk("R4", "stray wb_we", 1, 0);
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      finished = 1; total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R10", "reset ac", ac_q, 0);
    chk("R10", "reset link", link_q, 0);
    chk("R10", "reset ovf", ovf_q, 0);
    chk("R10", "reset done", done, 0);
    chk("R10", "reset wb_we", wb_we, 0);
    run(2'd0, 12'o2435, 12'o1704, 1'b1, "R1_R2_R3 add no carry");
    run(2'd0, 12'o2435, 12'o5704, 1'b0, "R1 add end-around");
    run(2'd1, 12'o2435, 12'o5704, 1'b1, "R4 add to memory");
    run(2'd0, 12'o3000, 12'o2000, 1'b0, "R5 positive overflow");
    run(2'd0, 12'o0001, 12'o0001, 1'b0, "R5 overflow cleared");
    run(2'd1, 12'o4000, 12'o4000, 1'b0, "R1_R5 negative overflow");
    run(2'd0, 12'o7777, 12'o0001, 1'b1, "R5 unlike signs");
    run(2'd2, 12'o3743, 12'o6517, 1'b1, "R6_R7 link add example");
    run(2'd2, 12'o7777, 12'o0005, 1'b1, "R6 first-step carry");
    run(2'd2, 12'o0001, 12'o0002, 1'b1, "R6 no carry clears");
    run(2'd2, 12'o3777, 12'o0001, 1'b0, "R7 link add overflow");
    run(2'd3, 12'o1234, 12'o4321, 1'b1, "R9 ignored op");
    run(2'd0, 12'o7777, 12'o0000, 1'b0, "R8 minus zero");
    run(2'd0, 12'o0000, 12'o0000, 1'b1, "R8 plus zero");
    run(2'd3, 12'o7000, 12'o7000, 1'b0, "R9 ignored op again");
    repeat (4) @(negedge clk);
    chk("R9", "pending results", q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule